// File: doc/BRIEF.md
# Cross-Domain Pause Counter

This block gives software a short, precise delay measured in oscillator periods. A write on the register bus loads a 16-bit start value. The countdown itself runs on the oscillator clock. Software then polls a single busy bit until it reads 0. The block only reports whether a countdown is running; the count itself is never read back.

The start command travels from the bus clock to the oscillator clock as a two-bit Gray-coded tag. A two-flop synchroniser carries the tag across, and the oscillator side echoes it back as an acknowledge. The value that goes with the tag is held constant until that acknowledge returns. The oscillator side also returns a done tag, and the bus side compares it with its own request tag to drive the busy bit.

A write of 0 does nothing. Start values of 1 to 3 are raised to 4. A write that arrives while a countdown runs restarts the countdown with the new value. If the previous hand-over has not yet been acknowledged, the latest value waits in a holding register and goes out next.

Top module: `osc_pause_counter`

## Requirements
- R1: After both resets, `busy` reads 0.
- R2: A write with non-zero `wr_data` makes `busy` read 1 from the first bus clock edge after the write. `busy` stays 1 until the countdown for the latest accepted value has finished.
- R3: Once the value has been loaded in the oscillator domain, the counter decrements once per oscillator cycle and reaches zero after exactly N cycles. It then stays at zero until the next load.
- R4: Written values 1, 2 and 3 produce the same countdown length as a written value of 4.
- R5: Writing 0 has no effect. It does not start an idle counter, and it neither stops nor restarts a running countdown.
- R6: A non-zero write during a running countdown reloads the counter with the new clamped value. `busy` does not drop between the two countdowns.
- R7: A write made while an earlier hand-over is still unacknowledged is kept in a holding register. Only the most recent such value is sent, and it is sent once the acknowledge arrives. The result is a single countdown of that value, with no drop of `busy` in between.
- R8: While a hand-over is unacknowledged, the value offered to the oscillator domain stays constant. The request tag advances one Gray step at a time (00, 01, 11, 10, then back to 00).
- R9: After the oscillator-domain counter reaches zero, `busy` falls within two synchroniser stages plus one register stage of the bus clock. This return latency is not compensated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe, one bus cycle |
| wr_data | input | 16 | Start value written with the strobe |
| busy | output | 1 | 1 while a countdown is pending or running |
| osc_clk | input | 1 | Oscillator clock that drives the countdown |
| osc_rst | input | 1 | Synchronous active-high reset, oscillator domain |

## Verification
The bench uses an oscillator clock five times slower than the bus clock. Each countdown length is checked as a window of bus cycles between the write and the falling edge of `busy`. The values 1, 2, 3, 4 and 7 separate clamped counts from unclamped ones: an unclamped 1 would end about a dozen cycles earlier than the window for 4. Several tests compare a first write with a later one, which shows whether the later value or the first one sets the end time. These are a zero write during a run, a reload well after the hand-over, and a write in the very next bus cycle while the first hand-over is still open. Counting falling edges of `busy` per test exposes any spurious gap between a reload and the new countdown.

// File: rtl/osc_pause_pkg.sv
package osc_pause_pkg;

  localparam int TAG_W = 2;
  typedef logic [TAG_W-1:0] tag_t;

  // One Gray step: only one bit changes, so the tag is safe to synchronise.
  function automatic tag_t tag_next(input tag_t t);
    tag_t n;
    case (t)
      2'b00:   n = 2'b01;
      2'b01:   n = 2'b11;
      2'b11:   n = 2'b10;
      default: n = 2'b00;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/osc_pause_sync.sv
module osc_pause_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= '0;
      else     stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/osc_pause_bus_side.sv
module osc_pause_bus_side
  import osc_pause_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  tag_t             ack_s,
  input  tag_t             done_s,
  output tag_t             req_tag,
  output logic [CNT_W-1:0] xfer_val,
  output logic             busy
);

  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CNT);

  tag_t             req_q;
  logic [CNT_W-1:0] xfer_q;
  logic [CNT_W-1:0] pend_val_q;
  logic             pend_q;
  logic             busy_q;

  logic             wr_ok;
  logic             in_flight;
  logic [CNT_W-1:0] clamped;

  assign wr_ok     = wr_en && (wr_data != '0);
  assign clamped   = (wr_data < MIN_V) ? MIN_V : wr_data;
  assign in_flight = (req_q != ack_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= '0;
      xfer_q     <= '0;
      pend_val_q <= '0;
      pend_q     <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      if (!in_flight && (wr_ok || pend_q)) begin
        xfer_q <= wr_ok ? clamped : pend_val_q;
        req_q  <= tag_next(req_q);
        pend_q <= 1'b0;
      end else if (wr_ok) begin
        pend_val_q <= clamped;
        pend_q     <= 1'b1;
      end
      busy_q <= wr_ok | pend_q | (req_q != done_s);
    end
  end

  assign req_tag  = req_q;
  assign xfer_val = xfer_q;
  assign busy     = busy_q;

  p_busy_after_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> busy_q);

  p_busy_while_pending_r7: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> busy_q);

  p_value_held_r8: assert property (@(posedge clk) disable iff (rst)
    (in_flight && (req_q == $past(req_q))) |-> $stable(xfer_q));

  p_tag_gray_step_r8: assert property (@(posedge clk) disable iff (rst)
    (req_q != $past(req_q)) |-> (req_q == tag_next($past(req_q))));

endmodule

// File: rtl/osc_pause_osc_side.sv
module osc_pause_osc_side
  import osc_pause_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  tag_t             req_s,
  input  logic [CNT_W-1:0] xfer_val,
  output tag_t             ack_tag,
  output tag_t             done_tag
);

  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CNT);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  tag_t             ack_q;
  tag_t             done_q;
  logic             load;

  assign load = (req_s != ack_q);

  // done trails ack by one Gray step while running and equals it when idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ack_q  <= '0;
      done_q <= '0;
    end else if (load) begin
      cnt_q  <= xfer_val;
      ack_q  <= req_s;
      done_q <= ack_q;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE_V;
      if (cnt_q == ONE_V) done_q <= ack_q;
    end
  end

  assign ack_tag  = ack_q;
  assign done_tag = done_q;

  p_load_clamped_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q >= MIN_V));

  p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q != '0) && !load) |=> (cnt_q == $past(cnt_q) - ONE_V));

  p_stop_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == '0) && !load) |=> ((cnt_q == '0) && $stable(done_q)));

endmodule

// File: rtl/osc_pause_counter.sv
module osc_pause_counter
  import osc_pause_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_CNT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             bus_clk,
  input  logic             bus_rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic             busy,
  input  logic             osc_clk,
  input  logic             osc_rst
);

  localparam int BACK_W = 2 * TAG_W;

  tag_t             req_tag;
  tag_t             req_s;
  tag_t             ack_tag;
  tag_t             done_tag;
  logic [CNT_W-1:0] xfer_val;
  logic [BACK_W-1:0] back_s;

  osc_pause_bus_side #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_bus (
    .clk      (bus_clk),
    .rst      (bus_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ack_s    (back_s[TAG_W-1:0]),
    .done_s   (back_s[BACK_W-1:TAG_W]),
    .req_tag  (req_tag),
    .xfer_val (xfer_val),
    .busy     (busy)
  );

  osc_pause_sync #(.W(TAG_W), .STAGES(SYNC_STAGES)) u_sync_req (
    .clk (osc_clk),
    .rst (osc_rst),
    .d   (req_tag),
    .q   (req_s)
  );

  osc_pause_osc_side #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_osc (
    .clk      (osc_clk),
    .rst      (osc_rst),
    .req_s    (req_s),
    .xfer_val (xfer_val),
    .ack_tag  (ack_tag),
    .done_tag (done_tag)
  );

  osc_pause_sync #(.W(BACK_W), .STAGES(SYNC_STAGES)) u_sync_back (
    .clk (bus_clk),
    .rst (bus_rst),
    .d   ({done_tag, ack_tag}),
    .q   (back_s)
  );

endmodule

// File: tb/osc_pause_counter_bench.sv
module osc_pause_counter_bench;

  logic        bus_clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        bus_rst = 1'b1;
  logic        osc_rst = 1'b1;
  logic        wr_en   = 1'b0;
  logic [15:0] wr_data = '0;
  logic        busy;

  always #4  bus_clk = ~bus_clk;   // 125 MHz bus clock
  always #20 osc_clk = ~osc_clk;   // oscillator, five bus periods

  osc_pause_counter u_osc_pause_counter (
    .bus_clk (bus_clk),
    .bus_rst (bus_rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .busy    (busy),
    .osc_clk (osc_clk),
    .osc_rst (osc_rst)
  );

  typedef struct { int n; int t0; int slack; string req; } exp_t;
  exp_t q[$];

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int falls = 0;
  logic busy_prev = 1'b0;
  bit   finished  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge bus_clk) cyc <= cyc + 1;

  // Monitor: on each busy fall, compare the elapsed bus cycles with the
  // window predicted for the most recent expected countdown.
  always @(negedge bus_clk) begin
    if (busy_prev && !busy) begin
      falls++;
      if (q.size() == 0) begin
        chk(1'b0, "R2 unexpected busy fall", 1, 0);
      end else begin
        exp_t e;
        int d, lo, hi;
        e  = q[$];
        q.delete();
        d  = cyc - e.t0;
        lo = 5 * e.n + 10;
        hi = 5 * e.n + 22 + e.slack;
        chk((d >= lo) && (d <= hi), e.req, d, lo);
      end
    end
    busy_prev = busy;
  end

  task automatic do_write(input logic [15:0] v, input int n_exp, input int slack,
                          input bit push, input string req);
    @(negedge bus_clk);
    wr_en   = 1'b1;
    wr_data = v;
    if (push) q.push_back('{n: n_exp, t0: cyc, slack: slack, req: req});
    @(negedge bus_clk);
    wr_en   = 1'b0;
    wr_data = '0;
    if (v != 0) chk(busy === 1'b1, "R2 busy after write", int'(busy), 1);
  endtask

  task automatic wait_idle();
    while (busy !== 1'b0 || q.size() != 0) @(negedge bus_clk);
    repeat (4) @(negedge bus_clk);
  endtask

  task automatic run_one(input logic [15:0] v, input int n_exp, input string req);
    int f0;
    f0 = falls;
    do_write(v, n_exp, 0, 1'b1, req);
    wait_idle();
    chk(falls == f0 + 1, "R3 one busy fall", falls - f0, 1);
  endtask

  initial begin
    repeat (6) @(negedge bus_clk);
    bus_rst = 1'b0;
    osc_rst = 1'b0;
    @(negedge bus_clk);
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    repeat (10) @(negedge bus_clk);
    chk(busy === 1'b0, "R1 idle stays idle", int'(busy), 0);

    // R3 and R9: plain countdowns of several lengths.
    run_one(16'd100, 100, "R3 R9 countdown 100");
    run_one(16'd7,   7,   "R3 countdown 7");
    run_one(16'd1000, 1000, "R3 countdown 1000");

    // R4: small values clamp to four.
    run_one(16'd1, 4, "R4 value 1 clamped");
    run_one(16'd2, 4, "R4 value 2 clamped");
    run_one(16'd3, 4, "R4 value 3 clamped");
    run_one(16'd4, 4, "R4 value 4");

    // R5: zero write while idle.
    begin
      int hi_seen;
      hi_seen = 0;
      do_write(16'd0, 0, 0, 1'b0, "R5");
      for (int i = 0; i < 20; i++) begin
        @(negedge bus_clk);
        if (busy !== 1'b0) hi_seen++;
      end
      chk(hi_seen == 0, "R5 zero write idle", hi_seen, 0);
    end

    // R5: zero write during a countdown leaves its length unchanged.
    begin
      int f0;
      f0 = falls;
      do_write(16'd60, 60, 0, 1'b1, "R5 zero during run");
      repeat (40) @(negedge bus_clk);
      do_write(16'd0, 0, 0, 1'b0, "R5");
      wait_idle();
      chk(falls == f0 + 1, "R5 one busy fall", falls - f0, 1);
    end

    // R6: reload while running, after the first hand-over completed.
    begin
      int f0;
      f0 = falls;
      do_write(16'd300, 300, 0, 1'b1, "R6 first");
      repeat (60) @(negedge bus_clk);
      do_write(16'd12, 12, 0, 1'b1, "R6 reload to 12");
      wait_idle();
      chk(falls == f0 + 1, "R6 no gap between countdowns", falls - f0, 1);
    end

    // R7: second write in the very next cycle, hand-over still open.
    begin
      int f0;
      f0 = falls;
      do_write(16'd500, 500, 0, 1'b1, "R7 first");
      do_write(16'd9, 9, 25, 1'b1, "R7 latest value 9");
      wait_idle();
      chk(falls == f0 + 1, "R7 single countdown", falls - f0, 1);
    end

    // R7 with a clamped latest value.
    begin
      int f0;
      f0 = falls;
      do_write(16'd400, 400, 0, 1'b1, "R7 first");
      do_write(16'd2, 4, 25, 1'b1, "R7 R4 latest value 2");
      wait_idle();
      chk(falls == f0 + 1, "R7 single countdown clamped", falls - f0, 1);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule